// File: doc/BRIEF.md
# Open-Drain Status Pin Selector

This block decides, every clock cycle, whether a shared open-drain data-out pin is pulled low or left released. Outside a serial transfer, a 3-bit function code chooses what the pin shows: nothing, a loss-of-lock warning, a latched "count finished" indication, or the level of one of two general-purpose port pins. While the serial chip-enable is high, the transfer direction takes over. An inbound transfer keeps the pin released, and an outbound transfer drives the pin from the serial data bit, which is updated on the falling edges of the serial clock.

Every input is treated as asynchronous and passes through a synchronizer chain before use. Start and end events for the IF count are edge-detected after that chain. The end of a count sets a sticky flag. A new count start clears the flag, and so does the opening of any serial transfer. The output is a registered pull-low enable that goes to the pad driver. The serial shift logic and the frequency counter sit outside the block.

Top module: `dout_pin_mux`

## Requirements
- R1: While `rst_n` is low, and after it is released until the inputs select otherwise, `pull_low` is 0. Reset also clears the count-complete flag.
- R2: With `ce` low, function codes 3'b000, 3'b011, 3'b100 and 3'b111 give `pull_low` = 0 regardless of the other inputs.
- R3: With `ce` low and code 3'b001, `pull_low` equals `unlocked` (1 = loop unlocked).
- R4: With `ce` low, code 3'b101 gives `pull_low` = 1 exactly when `port1_is_out` is 0 and `port1_level` is 0. Code 3'b110 does the same with `port2_is_out` and `port2_level`. A direction bit of 1 means the port is an output, and the pin is then released.
- R5: With `ce` low and code 3'b010, a rising edge on `count_done` sets the count-complete flag and pulls the pin low. A rising edge on `count_en` clears the flag and releases the pin. If both edges arrive together, the clear wins.
- R6: The count-complete flag is sticky. It stays set after `count_done` falls, while the function code changes, and when `count_en` falls.
- R7: A rising edge on `ce` clears the count-complete flag. The pin therefore stays released after the transfer ends.
- R8: While `ce` is high and `xfer_out` is 0 (inbound transfer), `pull_low` is 0 for every function code.
- R9: While `ce` is high and `xfer_out` is 1, `pull_low` is the inverse of the held serial bit. That bit is loaded from `ser_bit` on the rising edge of `ce` and again on every falling edge of `sclk`. A rising edge of `sclk` does not change it.
- R10: With `SYNC_STAGES` = 2, a level-path input change first appears on `pull_low` three clock edges later, never earlier. Every other input change appears within four clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fn_code | input | 3 | Function select code |
| ce | input | 1 | Serial chip-enable, high during a transfer |
| sclk | input | 1 | Serial clock |
| xfer_out | input | 1 | Transfer direction, 1 = outbound (readout) |
| ser_bit | input | 1 | Serial data bit presented for readout |
| unlocked | input | 1 | Loop-unlocked indicator, 1 = unlocked |
| count_en | input | 1 | Count enable, rising edge starts a count |
| count_done | input | 1 | Rising edge marks end of measurement |
| port1_level | input | 1 | Level of general-purpose port 1 |
| port2_level | input | 1 | Level of general-purpose port 2 |
| port1_is_out | input | 1 | Port 1 direction, 1 = output |
| port2_is_out | input | 1 | Port 2 direction, 1 = output |
| pull_low | output | 1 | Pad pull-low enable, 1 = drive pin low |

## Verification
The bench sweeps every function code against all combinations of the unlock and port inputs, then sweeps the overrides for both transfer directions. A wrong flag state shows up as `pull_low` being wrong under code 3'b010 within four edges of the event. A stale serial bit shows up as a wrong level after the next falling edge of `sclk`. An extra or missing pipeline register is caught by sampling `pull_low` both two and four edges after a change.

// File: rtl/dpm_pkg.sv
// Package: shared function codes and synchronizer bus layout for the
// data-out pin selector. Assumes a 3-bit function field.
package dpm_pkg;

    typedef enum logic [2:0] {
        FN_OFF_A  = 3'b000,
        FN_UNLOCK = 3'b001,
        FN_CDONE  = 3'b010,
        FN_OFF_B  = 3'b011,
        FN_OFF_C  = 3'b100,
        FN_PORT1  = 3'b101,
        FN_PORT2  = 3'b110,
        FN_OFF_D  = 3'b111
    } fn_code_t;

    localparam int FN_W    = 3;
    // bit positions inside the synchronizer bus
    localparam int B_CE    = 0;
    localparam int B_SCLK  = 1;
    localparam int B_XOUT  = 2;
    localparam int B_SBIT  = 3;
    localparam int B_UNL   = 4;
    localparam int B_CEN   = 5;
    localparam int B_CDN   = 6;
    localparam int B_P1L   = 7;
    localparam int B_P2L   = 8;
    localparam int B_P1D   = 9;
    localparam int B_P2D   = 10;
    localparam int B_FN    = 11;
    localparam int SYNC_W  = B_FN + FN_W;

    // edge-detect vector layout
    localparam int E_CE    = 0;
    localparam int E_CEN   = 1;
    localparam int E_CDN   = 2;
    localparam int EDGE_W  = 3;

endpackage

// File: rtl/dpm_sync.sv
// Module: multi-bit synchronizer chain. Each bit is independent; no
// coherency between bits is assumed. Resets every stage to zero.
module dpm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // one flop rank of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else if (g == 0) stg[g] <= d;
                else stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dpm_edge.sv
// Module: rising-edge detector on already synchronized levels.
// Assumes inputs are stable relative to clk. Output pulses one cycle.
module dpm_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    // remember last level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/dpm_cnt_flag.sv
// Module: sticky count-complete flag. Set by end-of-count edge, cleared
// by count start or transfer open; clear has priority over set.
module dpm_cnt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rise,
    input  logic done_rise,
    input  logic ce_rise,
    output logic flag
);
    // flag update with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else if (start_rise || ce_rise) flag <= 1'b0;
        else if (done_rise) flag <= 1'b1;
    end
endmodule

// File: rtl/dpm_ser_latch.sv
// Module: holds the readout bit for the pin. Loads on transfer open and on
// every falling serial clock edge. Assumes synchronized inputs.
module dpm_ser_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sbit_s,
    input  logic ce_rise,
    output logic held
);
    logic sclk_prev;
    logic sclk_fall;

    // track previous serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else sclk_prev <= sclk_s;
    end

    assign sclk_fall = sclk_prev & ~sclk_s;

    // capture serial bit at transfer open or clock fall
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 1'b1;
        else if (ce_rise || sclk_fall) held <= sbit_s;
    end
endmodule

// File: rtl/dpm_out_sel.sv
// Module: selects the pin function and registers the pull-low enable.
// Transfer overrides take precedence over the function code.
module dpm_out_sel
    import dpm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FN_W-1:0] fn_s,
    input  logic            ce_s,
    input  logic            xout_s,
    input  logic            held_bit,
    input  logic            unl_s,
    input  logic            flag,
    input  logic            p1l_s,
    input  logic            p2l_s,
    input  logic            p1d_s,
    input  logic            p2d_s,
    output logic            pull_low
);
    fn_code_t fn;
    logic     pull_nxt;

    assign fn = fn_code_t'(fn_s);

    // function decode with transfer override
    always_comb begin
        pull_nxt = 1'b0;
        if (ce_s) begin
            pull_nxt = xout_s ? ~held_bit : 1'b0;
        end else begin
            unique case (fn)
                FN_UNLOCK: pull_nxt = unl_s;
                FN_CDONE:  pull_nxt = flag;
                FN_PORT1:  pull_nxt = ~p1d_s & ~p1l_s;
                FN_PORT2:  pull_nxt = ~p2d_s & ~p2l_s;
                default:   pull_nxt = 1'b0;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) pull_low <= 1'b0;
        else pull_low <= pull_nxt;
    end
endmodule

// File: rtl/dout_pin_mux.sv
// Module: top of the open-drain data-out pin selector. Synchronizes all
// inputs, detects events, keeps the count-complete flag and readout bit,
// and drives a registered pull-low enable. Inputs assumed asynchronous.
module dout_pin_mux
    import dpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FN_W-1:0] fn_code,
    input  logic            ce,
    input  logic            sclk,
    input  logic            xfer_out,
    input  logic            ser_bit,
    input  logic            unlocked,
    input  logic            count_en,
    input  logic            count_done,
    input  logic            port1_level,
    input  logic            port2_level,
    input  logic            port1_is_out,
    input  logic            port2_is_out,
    output logic            pull_low
);
    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic [EDGE_W-1:0] edge_lvl;
    logic [EDGE_W-1:0] edge_rise;

    logic            ce_s, xout_s, unl_s;
    logic [FN_W-1:0] fn_s;
    logic            p1d_s;
    logic            start_rise, ce_rise, done_rise;
    logic            cnt_flag, held_bit;

    always_comb begin
        raw_bus                    = '0;
        raw_bus[B_CE]              = ce;
        raw_bus[B_SCLK]            = sclk;
        raw_bus[B_XOUT]            = xfer_out;
        raw_bus[B_SBIT]            = ser_bit;
        raw_bus[B_UNL]             = unlocked;
        raw_bus[B_CEN]             = count_en;
        raw_bus[B_CDN]             = count_done;
        raw_bus[B_P1L]             = port1_level;
        raw_bus[B_P2L]             = port2_level;
        raw_bus[B_P1D]             = port1_is_out;
        raw_bus[B_P2D]             = port2_is_out;
        raw_bus[B_FN +: FN_W]      = fn_code;
    end

    dpm_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    assign ce_s   = sync_bus[B_CE];
    assign xout_s = sync_bus[B_XOUT];
    assign unl_s  = sync_bus[B_UNL];
    assign fn_s   = sync_bus[B_FN +: FN_W];
    assign p1d_s  = sync_bus[B_P1D];

    always_comb begin
        edge_lvl        = '0;
        edge_lvl[E_CE]  = sync_bus[B_CE];
        edge_lvl[E_CEN] = sync_bus[B_CEN];
        edge_lvl[E_CDN] = sync_bus[B_CDN];
    end

    dpm_edge #(.W(EDGE_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (edge_lvl),
        .rise  (edge_rise)
    );

    assign ce_rise    = edge_rise[E_CE];
    assign start_rise = edge_rise[E_CEN];
    assign done_rise  = edge_rise[E_CDN];

    dpm_cnt_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rise (start_rise),
        .done_rise  (done_rise),
        .ce_rise    (ce_rise),
        .flag       (cnt_flag)
    );

    dpm_ser_latch u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sync_bus[B_SCLK]),
        .sbit_s  (sync_bus[B_SBIT]),
        .ce_rise (ce_rise),
        .held    (held_bit)
    );

    dpm_out_sel u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn_s     (fn_s),
        .ce_s     (ce_s),
        .xout_s   (xout_s),
        .held_bit (held_bit),
        .unl_s    (unl_s),
        .flag     (cnt_flag),
        .p1l_s    (sync_bus[B_P1L]),
        .p2l_s    (sync_bus[B_P2L]),
        .p1d_s    (p1d_s),
        .p2d_s    (sync_bus[B_P2D]),
        .pull_low (pull_low)
    );
endmodule

// File: rtl/dpm_checker.sv
// Module: property checker for dout_pin_mux, attached by bind. Observes the
// synchronized levels and internal state against the registered pin output.
module dpm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pull_low,
    input logic       ce_s,
    input logic       xout_s,
    input logic       unl_s,
    input logic [2:0] fn_s,
    input logic       p1d_s,
    input logic       start_rise,
    input logic       ce_rise,
    input logic       cnt_flag,
    input logic       held_bit
);
    AST_RESET_OPEN: assert property (@(posedge clk)
        !rst_n |=> !pull_low); // R1

    AST_OFF_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && (fn_s == 3'b000 || fn_s == 3'b011 || fn_s == 3'b100 || fn_s == 3'b111))
        |=> !pull_low); // R2

    AST_UNLOCK_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && fn_s == 3'b001) |=> (pull_low == $past(unl_s))); // R3

    AST_PORT_OUT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && fn_s == 3'b101 && p1d_s) |=> !pull_low); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> !cnt_flag); // R5

    AST_CE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rise |=> !cnt_flag); // R7

    AST_IN_XFER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && !xout_s) |=> !pull_low); // R8

    AST_OUT_XFER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && xout_s) |=> (pull_low == !$past(held_bit))); // R9
endmodule

bind dout_pin_mux dpm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_low   (pull_low),
    .ce_s       (ce_s),
    .xout_s     (xout_s),
    .unl_s      (unl_s),
    .fn_s       (fn_s),
    .p1d_s      (p1d_s),
    .start_rise (start_rise),
    .ce_rise    (ce_rise),
    .cnt_flag   (cnt_flag),
    .held_bit   (held_bit)
);

// File: tb/sim_dout_pin_mux.sv
// Bench: sweeps function codes and overrides, computes expected pin state.
module sim_dout_pin_mux;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fn_code = 3'b000;
    logic       ce = 0, sclk = 0, xfer_out = 0, ser_bit = 1, unlocked = 0;
    logic       count_en = 0, count_done = 0;
    logic       port1_level = 0, port2_level = 0, port1_is_out = 0, port2_is_out = 0;
    logic       pull_low;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dout_pin_mux u0 (
        .clk(clk), .rst_n(rst_n), .fn_code(fn_code), .ce(ce), .sclk(sclk),
        .xfer_out(xfer_out), .ser_bit(ser_bit), .unlocked(unlocked),
        .count_en(count_en), .count_done(count_done),
        .port1_level(port1_level), .port2_level(port2_level),
        .port1_is_out(port1_is_out), .port2_is_out(port2_is_out),
        .pull_low(pull_low)
    );

    task automatic chk(input logic exp, input string tag);
        total++;
        if (pull_low !== exp) begin
            bad++;
            $display("FAIL %s: pull_low=%b expected=%b at %0t", tag, pull_low, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (LAT) @(negedge clk);
    endtask

    task automatic done_pulse();
        count_done = 1; settle();
        count_done = 0; settle();
    endtask

    // expected pin state with ce low and flag clear
    function automatic logic model(input logic [2:0] c, input logic u,
                                   input logic l1, input logic l2,
                                   input logic d1, input logic d2);
        case (c)
            3'b001:  return u;
            3'b101:  return !d1 && !l1;
            3'b110:  return !d2 && !l2;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(1'b0, "R1 in reset");
        rst_n = 1;
        settle();
        chk(1'b0, "R1 after reset");

        // R2 R3 R4: full sweep with ce low
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 32; m++) begin
                fn_code = s[2:0];
                {unlocked, port1_level, port2_level, port1_is_out, port2_is_out} = m[4:0];
                settle();
                chk(model(s[2:0], m[4], m[3], m[2], m[1], m[0]),
                    (s == 1) ? "R3" : (s == 5 || s == 6) ? "R4" : (s == 2) ? "R5" : "R2");
            end
        end
        {unlocked, port1_level, port2_level, port1_is_out, port2_is_out} = 5'b0;

        // R10: latency of level path
        fn_code = 3'b001; settle();
        unlocked = 1;
        repeat (2) @(negedge clk);
        chk(1'b0, "R10 not before third edge");
        repeat (2) @(negedge clk);
        chk(1'b1, "R10 within four edges");
        unlocked = 0; settle();

        // R5 R6 R7: count-complete flag
        fn_code = 3'b010;
        count_en = 1; settle();
        chk(1'b0, "R5 start releases");
        count_done = 1; settle();
        chk(1'b1, "R5 end pulls low");
        count_done = 0; settle();
        chk(1'b1, "R6 sticky after done falls");
        fn_code = 3'b000; settle();
        chk(1'b0, "R2 code change hides flag");
        fn_code = 3'b010; settle();
        chk(1'b1, "R6 flag kept across code change");
        count_en = 0; settle();
        chk(1'b1, "R6 count_en fall ignored");
        count_en = 1; settle();
        chk(1'b0, "R5 new start clears");
        count_en = 0;
        done_pulse();
        chk(1'b1, "R5 set again");
        count_en = 1; count_done = 1; settle();
        chk(1'b0, "R5 clear wins over set");
        count_done = 0; count_en = 0; settle();
        done_pulse();
        ce = 1; xfer_out = 0; settle();
        chk(1'b0, "R8 inbound transfer opens");
        ce = 0; settle();
        chk(1'b0, "R7 transfer cleared flag");
        done_pulse();
        ser_bit = 1; ce = 1; xfer_out = 1; settle();
        chk(1'b0, "R9 readout bit 1 releases");
        ce = 0; xfer_out = 0; settle();
        chk(1'b0, "R7 outbound transfer cleared flag");

        // R8: inbound override for every code, with low-pulling conditions
        unlocked = 1;
        for (int s = 0; s < 8; s++) begin
            fn_code = s[2:0];
            ce = 1; xfer_out = 0; settle();
            chk(1'b0, "R8 override");
            ce = 0; settle();
        end

        // R9: outbound readout for every code and both bit values
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < 2; b++) begin
                fn_code = s[2:0];
                ser_bit = b[0]; xfer_out = 1; ce = 1; settle();
                chk(!b[0], "R9 load at ce rise");
                ser_bit = !b[0]; sclk = 1; settle();
                chk(!b[0], "R9 sclk rise ignored");
                sclk = 0; settle();
                chk(b[0], "R9 update at sclk fall");
                ce = 0; xfer_out = 0; settle();
            end
        end
        unlocked = 0;

        // R1: reset clears a set flag
        fn_code = 3'b010;
        done_pulse();
        chk(1'b1, "R5 flag set before reset");
        rst_n = 0; repeat (3) @(negedge clk);
        chk(1'b0, "R1 open during reset");
        rst_n = 1; settle();
        chk(1'b0, "R1 flag cleared by reset");

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule